// File: doc/BRIEF.md
# Pipe Colour Matrix with Offsets

This block converts a stream of three-channel pixels through a programmable 3x3 matrix. Before the matrix, each channel is widened to a 12-bit working scale. Two optional biases can then be taken away from it: a chroma centre and a black level. A signed pre-offset is added next. The matrix works on the three adjusted channels. A signed post-offset is added to each result, and the result is rounded back to 10 bits and held inside the legal code range. Identity, RGB-to-YUV, YUV-to-RGB and range-compression transforms are all loaded through the same set of registers.

Each matrix entry is a 16-bit code: a sign, a 3-bit scale selector and a 9-bit mantissa. The scale selector moves the mantissa window, so that small coefficients keep their precision and coefficients near 4.0 can still be reached. Software writes into a shadow copy at any time. The shadow copy is moved into the working copy only on a frame-start strobe, so a frame is never processed with a mix of old and new settings.

Top module: `csc_matrix3`

## Requirements
- R1: A coefficient word holds the sign in bit 15, the scale selector in bits 14:12 and the mantissa in bits 11:3. Bits 2:0 have no effect on the result.
- R2: The scale selector sets the number of fraction bits of the mantissa: 3 gives 12, 2 gives 11, 1 gives 10, 0 gives 9, 7 gives 8 and 6 gives 7. Selectors 4 and 5 make the coefficient zero.
- R3: Register writes use these addresses. Addresses 0, 2 and 4 hold row r = addr/2: the first coefficient of the row in data[31:16] and the second in data[15:0]. Addresses 1, 3 and 5 hold the third coefficient of the same row in data[31:16], and data[15:0] is ignored. Addresses 6 to 8 hold the pre-offsets of channels 0 to 2, and addresses 9 to 11 hold the post-offsets of channels 0 to 2. Both kinds of offset are 13-bit two's complement values in data[12:0]. Address 12 holds the mode bits in data[1:0]. Addresses 13 to 15 are ignored.
- R4: A register write changes only the shadow copy. On a frame_start cycle, the working copy takes the shadow value held before any write in that same cycle. A pixel accepted in the frame_start cycle still uses the old settings.
- R5: After reset, both copies hold the unity code 0x7800 on the diagonal (coefficients 0, 4 and 8), zero coefficients elsewhere, zero offsets and zero mode bits. Each output pixel then equals its input pixel.
- R6: A pixel carries channel 0 in bits 29:20, channel 1 in bits 19:10 and channel 2 in bits 9:0. Each channel k gives x_k = 4*in_k - bias_k + pre_k. Output c is floor((sum over k of coef[3c+k]*x_k + 4096*post_c + 8192) / 16384), where coef is the decoded value scaled by 4096.
- R7: The rounded result saturates: a value below 0 gives 0, and a value above 1023 gives 1023.
- R8: Mode bit 0 (chroma centring) sets bias_k = 2048 for channels 1 and 2.
- R9: Mode bit 1 (black level) sets bias_k = 256 for every channel that mode bit 0 does not centre. Channels with no active mode bit have bias_k = 0.
- R10: out_valid rises exactly two cycles after in_valid. Pixels leave in arrival order, and no pixel is dropped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Moves the shadow settings into the working copy |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel is valid |
| in_pix | input | 30 | Input pixel, three 10-bit channels |
| out_valid | output | 1 | Output pixel is valid |
| out_pix | output | 30 | Output pixel, three 10-bit channels |

## Verification
The bench writes settings while pixels stream and pulses frame_start in the middle of a back-to-back burst. A design that loaded settings at write time, or that let one pipeline stage see new coefficients while another still used old offsets, would corrupt the pixels on either side of the boundary. Random coefficient words use every scale selector, including the reserved ones, and put garbage in the three low bits. This exposes a mantissa window shifted the wrong way, a reserved selector decoded as a real scale, or the low bits leaking into the product. Directed cases drive the sums far above and below the code range, apply each mode bit alone and together, and write the ignored addresses and half-words. These catch a wrap instead of a clamp, a bias on the wrong channel, and a write that lands where it should not.

// File: rtl/csc_pkg.sv
package csc_pkg;
   // coefficient code layout
   localparam int CW      = 16;
   localparam int MANT_W  = 9;
   localparam int FRAC    = 12;              // fraction bits of a decoded coefficient
   localparam int CMAG_W  = MANT_W + 5;      // largest window shift is 5
   localparam int CSG_W   = CMAG_W + 1;
   localparam int N_CH    = 3;
   localparam int N_COEF  = N_CH * N_CH;

   // register addresses
   localparam int A_PRE0  = 6;
   localparam int A_POST0 = 9;
   localparam int A_MODE  = 12;

   localparam logic [CW-1:0] UNITY = 16'h7800;

   function automatic logic [CW-1:0] reset_coef(input int idx);
      return (idx % (N_CH + 1) == 0) ? UNITY : '0;
   endfunction
endpackage

// File: rtl/csc_coef_dec.sv
module csc_coef_dec
   import csc_pkg::*;
(
   input  logic [CW-1:0]           word_i,
   output logic signed [CSG_W-1:0] coef_o
);
   logic [2:0]        shift;
   logic              live;
   logic [CMAG_W-1:0] mag;
   logic              unused_lsb;

   assign unused_lsb = ^word_i[2:0];

   always_comb begin
      live  = 1'b1;
      shift = 3'd0;
      unique case (word_i[14:12])
         3'd3:    shift = 3'd0;
         3'd2:    shift = 3'd1;
         3'd1:    shift = 3'd2;
         3'd0:    shift = 3'd3;
         3'd7:    shift = 3'd4;
         3'd6:    shift = 3'd5;
         default: live  = 1'b0;
      endcase
      mag    = live ? (CMAG_W'(word_i[11:3]) << shift) : '0;
      coef_o = word_i[15] ? -signed'({1'b0, mag}) : signed'({1'b0, mag});
   end

   // R2
   always_comb begin
      reserved_zero_chk: assert (!(word_i[14:13] == 2'b10) || coef_o == '0);
   end
endmodule

// File: rtl/csc_cfg_bank.sv
module csc_cfg_bank
   import csc_pkg::*;
#(
   parameter int OW = 13
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [3:0]                  addr,
   input  logic [31:0]                 wdata,
   input  logic                        frame_start,
   output logic [N_COEF-1:0][CW-1:0]   act_coef,
   output logic [N_CH-1:0][OW-1:0]     act_pre,
   output logic [N_CH-1:0][OW-1:0]     act_post,
   output logic [1:0]                  act_mode
);
   logic [N_COEF-1:0][CW-1:0] sh_coef;
   logic [N_CH-1:0][OW-1:0]   sh_pre, sh_post;
   logic [1:0]                sh_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_COEF; i++) begin
            sh_coef[i]  <= reset_coef(i);
            act_coef[i] <= reset_coef(i);
         end
         sh_pre   <= '0;
         sh_post  <= '0;
         sh_mode  <= '0;
         act_pre  <= '0;
         act_post <= '0;
         act_mode <= '0;
      end else begin
         if (frame_start) begin
            act_coef <= sh_coef;
            act_pre  <= sh_pre;
            act_post <= sh_post;
            act_mode <= sh_mode;
         end
         if (we) begin
            for (int r = 0; r < N_CH; r++) begin
               if (addr == 4'(2 * r)) begin
                  sh_coef[3*r]   <= wdata[31:16];
                  sh_coef[3*r+1] <= wdata[15:0];
               end
               if (addr == 4'(2 * r + 1))
                  sh_coef[3*r+2] <= wdata[31:16];
               if (addr == 4'(A_PRE0 + r))
                  sh_pre[r] <= wdata[OW-1:0];
               if (addr == 4'(A_POST0 + r))
                  sh_post[r] <= wdata[OW-1:0];
            end
            if (addr == 4'(A_MODE))
               sh_mode <= wdata[1:0];
         end
      end
   end

   // R4
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable({act_coef, act_pre, act_post, act_mode}));

   // R3
   pre_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 4'(A_PRE0)) |=> (sh_pre[0] == $past(wdata[OW-1:0])));
endmodule

// File: rtl/csc_dot_row.sv
module csc_dot_row
   import csc_pkg::*;
#(
   parameter int PIX_W = 10,
   parameter int X_W   = 15,
   parameter int OW    = 13
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en1,
   input  logic                       en2,
   input  logic [N_CH-1:0][X_W-1:0]   x_i,
   input  logic [N_CH-1:0][CSG_W-1:0] coef_i,
   input  logic [OW-1:0]              post_i,
   output logic [PIX_W-1:0]           out_o
);
   localparam int P_W   = X_W + CSG_W;
   localparam int ACC_W = P_W + 3;
   localparam int SH    = FRAC + 2;
   localparam int MAXV  = (1 << PIX_W) - 1;

   logic [N_CH-1:0][P_W-1:0] prod;
   logic signed [ACC_W-1:0]  acc, quo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod <= '0;
      else if (en1)
         for (int k = 0; k < N_CH; k++)
            prod[k] <= P_W'(signed'(x_i[k])) * P_W'(signed'(coef_i[k]));
   end

   always_comb begin
      acc = ACC_W'(signed'(post_i)) <<< FRAC;
      for (int k = 0; k < N_CH; k++)
         acc = acc + ACC_W'(signed'(prod[k]));
      quo = (acc + ACC_W'(1 << (SH - 1))) >>> SH;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_o <= '0;
      else if (en2) begin
         if (quo < 0)                     out_o <= '0;
         else if (quo > ACC_W'(MAXV))     out_o <= PIX_W'(MAXV);
         else                             out_o <= quo[PIX_W-1:0];
      end
   end

   // R7
   neg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en2 && quo < 0) |=> (out_o == '0));
   // R7
   high_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en2 && quo > ACC_W'(MAXV)) |=> (out_o == PIX_W'(MAXV)));
endmodule

// File: rtl/csc_matrix3.sv
module csc_matrix3
   import csc_pkg::*;
#(
   parameter int PIX_W = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_start,
   input  logic                  reg_we,
   input  logic [3:0]            reg_addr,
   input  logic [31:0]           reg_wdata,
   input  logic                  in_valid,
   input  logic [3*PIX_W-1:0]    in_pix,
   output logic                  out_valid,
   output logic [3*PIX_W-1:0]    out_pix
);
   localparam int IW     = FRAC;           // working scale of one channel
   localparam int OW     = IW + 1;
   localparam int X_W    = IW + 3;
   localparam int CENTER = 1 << (IW - 1);
   localparam int BLACK  = 1 << (IW - 4);

   generate
      if (PIX_W != IW - 2) begin : g_bad_width
         $error("PIX_W must be two bits below the working scale");
      end
   endgenerate

   logic [N_COEF-1:0][CW-1:0]    act_coef;
   logic [N_CH-1:0][OW-1:0]      act_pre, act_post, post_d;
   logic [1:0]                   act_mode;
   logic [N_COEF-1:0][CSG_W-1:0] dec;
   logic [N_CH-1:0][X_W-1:0]     xin;
   logic                         s1_valid;

   csc_cfg_bank #(.OW(OW)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .frame_start(frame_start), .act_coef(act_coef), .act_pre(act_pre),
      .act_post(act_post), .act_mode(act_mode)
   );

   for (genvar i = 0; i < N_COEF; i++) begin : g_dec
      csc_coef_dec u_dec (.word_i(act_coef[i]), .coef_o(dec[i]));
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_in
      logic signed [X_W-1:0] bias;
      always_comb begin
         if (act_mode[0] && c != 0) bias = X_W'(CENTER);
         else if (act_mode[1])      bias = X_W'(BLACK);
         else                       bias = '0;
         xin[c] = signed'(X_W'({in_pix[(2-c)*PIX_W +: PIX_W], 2'b00}))
                  - bias + X_W'(signed'(act_pre[c]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         out_valid <= 1'b0;
         post_d    <= '0;
      end else begin
         s1_valid  <= in_valid;
         out_valid <= s1_valid;
         if (in_valid) post_d <= act_post;
      end
   end

   for (genvar r = 0; r < N_CH; r++) begin : g_row
      csc_dot_row #(.PIX_W(PIX_W), .X_W(X_W), .OW(OW)) u_row (
         .clk(clk), .rst_n(rst_n), .en1(in_valid), .en2(s1_valid),
         .x_i(xin), .coef_i(dec[3*r+2 : 3*r]), .post_i(post_d[r]),
         .out_o(out_pix[(2-r)*PIX_W +: PIX_W])
      );
   end

   // R10
   stage1_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s1_valid);
   // R10
   out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_valid);
   // R10
   no_extra_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !out_valid);
endmodule

// File: tb/csc_matrix3_bench.sv
`timescale 1ns/1ps
module csc_matrix3_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_start = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        in_valid = 1'b0;
   logic [29:0] in_pix = '0;
   logic        out_valid;
   logic [29:0] out_pix;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   string cur_tag = "R5";

   // model state
   logic [15:0] s_coef[9], a_coef[9];
   logic [12:0] s_pre[3], a_pre[3], s_post[3], a_post[3];
   logic [1:0]  s_mode, a_mode;

   int          q_cyc[$];
   logic [29:0] q_dat[$];
   string       q_tag[$];

   always #2.5 clk = ~clk;

   csc_matrix3 u_csc_matrix3 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .in_valid(in_valid),
      .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic longint s13(input logic [12:0] v);
      return v[12] ? longint'(v) - 8192 : longint'(v);
   endfunction

   function automatic longint cval(input logic [15:0] w);
      int fr;
      longint m;
      case (w[14:12])
         3'd3: fr = 12;
         3'd2: fr = 11;
         3'd1: fr = 10;
         3'd0: fr = 9;
         3'd7: fr = 8;
         3'd6: fr = 7;
         default: fr = -1;
      endcase
      if (fr < 0) return 0;
      m = longint'(w[11:3]) << (12 - fr);
      return w[15] ? -m : m;
   endfunction

   function automatic logic [29:0] model(input logic [29:0] p);
      longint x[3];
      longint acc, q, bias;
      logic [29:0] res;
      res = '0;
      for (int k = 0; k < 3; k++) begin
         bias = 0;
         if (a_mode[0] && k != 0) bias = 2048;
         else if (a_mode[1]) bias = 256;
         x[k] = 4 * longint'(p[(2-k)*10 +: 10]) - bias + s13(a_pre[k]);
      end
      for (int r = 0; r < 3; r++) begin
         acc = 4096 * s13(a_post[r]);
         for (int k = 0; k < 3; k++) acc += cval(a_coef[3*r+k]) * x[k];
         q = (acc + 8192) >>> 14;
         if (q < 0) q = 0;
         if (q > 1023) q = 1023;
         res[(2-r)*10 +: 10] = 10'(q);
      end
      return res;
   endfunction

   function automatic void model_write(input logic [3:0] a, input logic [31:0] d);
      for (int r = 0; r < 3; r++) begin
         if (a == 4'(2*r)) begin s_coef[3*r] = d[31:16]; s_coef[3*r+1] = d[15:0]; end
         if (a == 4'(2*r+1)) s_coef[3*r+2] = d[31:16];
         if (a == 4'(6+r)) s_pre[r] = d[12:0];
         if (a == 4'(9+r)) s_post[r] = d[12:0];
      end
      if (a == 4'd12) s_mode = d[1:0];
   endfunction

   // one clock: check outputs, drive inputs, update model
   task automatic step(input bit we, input logic [3:0] a, input logic [31:0] d,
                       input bit fs, input bit v, input logic [29:0] p);
      bit exp_v;
      exp_v = (q_cyc.size() > 0) && (q_cyc[0] + 2 == cyc);
      if (out_valid || exp_v) begin
         chk(out_valid == exp_v, "R10 valid timing", 32'(out_valid), 32'(exp_v));
         if (out_valid && exp_v) begin
            chk(out_pix == q_dat[0], q_tag[0], 32'(out_pix), 32'(q_dat[0]));
            void'(q_cyc.pop_front());
            void'(q_dat.pop_front());
            void'(q_tag.pop_front());
         end
      end
      reg_we = we; reg_addr = a; reg_wdata = d;
      frame_start = fs; in_valid = v; in_pix = p;
      if (v) begin
         q_cyc.push_back(cyc);
         q_dat.push_back(model(p));
         q_tag.push_back(cur_tag);
      end
      if (fs) begin
         a_coef = s_coef; a_pre = s_pre; a_post = s_post; a_mode = s_mode;
      end
      if (we) model_write(a, d);
      cyc++;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      step(1'b1, a, d, 1'b0, 1'b0, '0);
   endtask

   task automatic pix(input logic [29:0] p);
      step(1'b0, '0, '0, 1'b0, 1'b1, p);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, 1'b0, '0);
   endtask

   task automatic commit();
      step(1'b0, '0, '0, 1'b1, 1'b0, '0);
   endtask

   function automatic logic [15:0] rand_coef();
      logic [2:0] code;
      code = 3'($urandom_range(0, 7));
      return {1'($urandom), code, 9'($urandom), 3'($urandom)};
   endfunction

   task automatic load_diag(input logic [15:0] w, input logic [12:0] pre, input logic [12:0] post,
                            input logic [1:0] mode);
      wr(4'd0, {w, 16'h0});
      wr(4'd1, 32'h0);
      wr(4'd2, {16'h0, w});
      wr(4'd3, 32'h0);
      wr(4'd4, 32'h0);
      wr(4'd5, {w, 16'h0});
      for (int c = 0; c < 3; c++) begin
         wr(4'(6 + c), {19'h0, pre});
         wr(4'(9 + c), {19'h0, post});
      end
      wr(4'd12, {30'h0, mode});
      commit();
   endtask

   task automatic rand_pixels(input int n);
      for (int i = 0; i < n; i++) begin
         if ($urandom_range(0, 3) == 0) idle(1);
         pix(30'($urandom));
      end
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd4242);
      for (int i = 0; i < 9; i++) begin
         s_coef[i] = (i % 4 == 0) ? 16'h7800 : 16'h0;
         a_coef[i] = s_coef[i];
      end
      for (int c = 0; c < 3; c++) begin
         s_pre[c] = '0; a_pre[c] = '0; s_post[c] = '0; a_post[c] = '0;
      end
      s_mode = '0; a_mode = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(out_valid == 1'b0, "R5 reset valid", 32'(out_valid), 0);

      // R5 identity after reset, including extremes
      cur_tag = "R5 identity";
      pix(30'h0);
      pix(30'h3FFF_FFFF);
      pix({10'd1, 10'd512, 10'd1022});
      rand_pixels(10);
      idle(3);

      // R4 writes without frame_start leave working settings unchanged
      cur_tag = "R4 shadow only";
      for (int a = 0; a < 12; a++) wr(4'(a), $urandom);
      rand_pixels(8);

      // R4 frame boundary inside a burst
      cur_tag = "R4 frame boundary";
      pix(30'($urandom));
      step(1'b0, '0, '0, 1'b1, 1'b1, 30'($urandom));
      pix(30'($urandom));
      pix(30'($urandom));
      // R4 write in the same cycle as frame_start
      step(1'b1, 4'd0, {16'h3100, 16'h2208}, 1'b1, 1'b1, 30'($urandom));
      pix(30'($urandom));
      commit();
      pix(30'($urandom));
      idle(3);

      // R6 R1 R2 random settings rounds
      for (int round = 0; round < 12; round++) begin
         cur_tag = "R6 R1 R2 random";
         for (int r = 0; r < 3; r++) begin
            wr(4'(2*r), {rand_coef(), rand_coef()});
            wr(4'(2*r+1), {rand_coef(), 16'($urandom)});
         end
         for (int c = 0; c < 3; c++) begin
            wr(4'(6 + c), $urandom);
            wr(4'(9 + c), $urandom);
         end
         wr(4'd12, 32'($urandom_range(0, 3)));
         commit();
         rand_pixels(40);
      end
      idle(3);

      // R7 saturation high: diagonal close to 4.0
      cur_tag = "R7 high clamp";
      load_diag(16'h6FF8, 13'h0, 13'h0, 2'b00);
      pix(30'h3FFF_FFFF);
      pix({10'd300, 10'd256, 10'd257});
      // R7 saturation low: negative diagonal
      cur_tag = "R7 low clamp";
      load_diag(16'hF800, 13'h0, 13'h0, 2'b00);
      pix({10'd5, 10'd1023, 10'd1});
      load_diag(16'h7800, 13'h0, 13'h1F00, 2'b00);
      pix({10'd10, 10'd100, 10'd1023});

      // R2 reserved scale selectors
      cur_tag = "R2 reserved code";
      load_diag(16'h4FF8, 13'h0, 13'h100, 2'b00);
      pix(30'h3FFF_FFFF);
      load_diag(16'hD800, 13'h0, 13'h0, 2'b00);
      pix({10'd700, 10'd1, 10'd999});

      // R1 low bits ignored, several scale windows
      cur_tag = "R1 low bits";
      load_diag(16'h3FFF, 13'h0, 13'h0, 2'b00);
      pix({10'd1023, 10'd512, 10'd77});
      load_diag(16'h0807, 13'h0, 13'h0, 2'b00);
      pix({10'd1023, 10'd512, 10'd77});

      // R8 R9 modes
      cur_tag = "R8 chroma centre";
      load_diag(16'h7800, 13'h0, 13'h800, 2'b01);
      pix({10'd512, 10'd512, 10'd600});
      pix({10'd0, 10'd0, 10'd1023});
      cur_tag = "R9 black level";
      load_diag(16'h7800, 13'h0, 13'h0, 2'b10);
      pix({10'd64, 10'd63, 10'd1023});
      cur_tag = "R8 R9 both";
      load_diag(16'h7800, 13'h0, 13'h0, 2'b11);
      pix({10'd64, 10'd512, 10'd700});

      // R3 ignored addresses and ignored half word
      cur_tag = "R3 ignored writes";
      load_diag(16'h7800, 13'h0, 13'h0, 2'b00);
      wr(4'd13, 32'hFFFF_FFFF);
      wr(4'd14, 32'h1234_5678);
      wr(4'd15, 32'h7800_7800);
      wr(4'd1, {16'h0000, 16'h7800});
      commit();
      pix({10'd100, 10'd200, 10'd300});
      // R3 pre-offset on channel 1 only
      cur_tag = "R3 pre offset";
      wr(4'd1, 32'h0);
      wr(4'd7, 32'h0000_0400);
      commit();
      pix({10'd100, 10'd200, 10'd300});

      idle(4);
      chk(q_cyc.size() == 0, "R10 all pixels out", 32'(q_cyc.size()), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule